// File: doc/BRIEF.md
# Receive Queue Flow-Control Monitor

This block watches how full a receive queue is and raises a flow-control request with hysteresis. The request rises when the fill level reaches an activate threshold. It falls only after the level drops below a lower deactivate threshold. Both thresholds are given as an amount below the top of the queue. A 6-bit code n stands for 1 KB + n × 512 bytes under the full mark. The full mark is set by a programmable queue-size field.

Alongside the request, the block reports a 2-bit fill status. The status tells whether the queue is empty or full. Between those two it tells which side of the hysteresis band the level was last on. The request is produced only while hardware flow control is enabled and the programmed configuration is usable. The queue memory and the pause-frame logic that consumes the request are outside this block.

A small state machine holds the hysteresis. The states are:
- `ST_IDLE`: flow control is off or the configuration is unusable.
- `ST_RELEASED`: flow control is armed and the request is low.
- `ST_ASSERTED`: the request is raised.

The transitions are:
- Any state goes to `ST_IDLE` whenever enable is low or the configuration is rejected.
- `ST_IDLE` or `ST_RELEASED` goes to `ST_ASSERTED` when level ≥ activate threshold.
- `ST_IDLE` goes to `ST_RELEASED` otherwise.
- `ST_ASSERTED` goes to `ST_RELEASED` when level < deactivate threshold.

Top module: `rxq_fc_monitor`

## Requirements
- R1: The queue capacity is (size field + 1) × 256 bytes. When the fill level is at or above the capacity, the status is 3 (full).
- R2: A fill level of 0 gives status 0 (empty). This holds in every state.
- R3: From an armed state, a level at or above the activate threshold raises the request on the next clock edge. The activate threshold is capacity − 1024 − 512 × activate code. The status becomes 2 (high) unless the queue is full or empty.
- R4: From the asserted state, a level below the deactivate threshold drops the request on the next clock edge. The deactivate threshold is capacity − 1024 − 512 × deactivate code. The status then reads 1 (low) unless the queue is empty.
- R5: While the level lies between the two thresholds, the request keeps its value and the status keeps reporting the side last crossed.
- R6: The request rises only through a crossing of the activate threshold. A level that stays below that threshold never raises it.
- R7: Clearing the enable drops the request in the same cycle, before any clock edge. After the next edge the machine rests in `ST_IDLE`, with status 1 for a non-empty, non-full queue.
- R8: A capacity below 4096 bytes holds the request low.
- R9: A code is illegal when its threshold would fall below 512 bytes. An illegal code holds the request low. An activate code that is not smaller than the deactivate code also holds it low.
- R10: After reset the request is low and the machine is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fc_en_i | input | 1 | Hardware flow-control enable |
| q_size_i | input | SIZE_W | Queue size field, in 256-byte blocks minus one |
| act_code_i | input | CODE_W | Activate threshold code |
| deact_code_i | input | CODE_W | Deactivate threshold code |
| fill_lvl_i | input | LVL_W | Current queue fill level in bytes |
| fc_req_o | output | 1 | Flow-control request |
| fill_stat_o | output | 2 | Fill status: 0 empty, 1 low, 2 high, 3 full |

## Verification
Results that depend on a threshold crossing or on a configuration change come from the state register. They are therefore due one clock edge after the inputs change. Empty and full status, and the effect of clearing the enable on the request, are combinational and due in the same cycle.

The driver changes inputs just after a falling edge and pushes the expected result. The monitor compares at the following falling edge, so each check sees exactly one rising edge. Same-cycle results are compared directly, 1 ns after the drive, before any edge.

// File: rtl/rxq_fc_pkg.sv
package rxq_fc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RELEASED = 2'd1,
        ST_ASSERTED = 2'd2
    } fc_state_e;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_LOW   = 2'd1,
        FILL_HIGH  = 2'd2,
        FILL_FULL  = 2'd3
    } fill_stat_e;

    localparam int unsigned BLOCK_BYTES = 256;
    localparam int unsigned BASE_BYTES  = 1024;
    localparam int unsigned STEP_SHIFT  = 9;     // 512-byte steps
    localparam int unsigned MIN_THR     = 512;
    localparam int unsigned MIN_CAP     = 4096;

endpackage

// File: rtl/rxq_fc_code2thr.sv
module rxq_fc_code2thr
    import rxq_fc_pkg::*;
#(
    parameter int unsigned LVL_W  = 16,
    parameter int unsigned CODE_W = 6
) (
    input  logic [LVL_W-1:0]  cap_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [LVL_W-1:0]  thr_o,
    output logic              legal_o
);
    logic [LVL_W-1:0] below_full;

    always_comb begin
        below_full = LVL_W'(BASE_BYTES) + (LVL_W'(code_i) << STEP_SHIFT);
        legal_o    = cap_i >= (below_full + LVL_W'(MIN_THR));
        thr_o      = cap_i - below_full;
    end
endmodule

// File: rtl/rxq_fc_cfg.sv
module rxq_fc_cfg
    import rxq_fc_pkg::*;
#(
    parameter int unsigned LVL_W  = 16,
    parameter int unsigned SIZE_W = 7,
    parameter int unsigned CODE_W = 6
) (
    input  logic [SIZE_W-1:0] q_size_i,
    input  logic [CODE_W-1:0] act_code_i,
    input  logic [CODE_W-1:0] deact_code_i,
    output logic [LVL_W-1:0]  cap_o,
    output logic [LVL_W-1:0]  act_thr_o,
    output logic [LVL_W-1:0]  deact_thr_o,
    output logic              cfg_ok_o
);
    localparam int unsigned NTHR = 2;

    logic [CODE_W-1:0] codes [NTHR];
    logic [LVL_W-1:0]  thrs  [NTHR];
    logic [NTHR-1:0]   legal;

    assign codes[0] = act_code_i;
    assign codes[1] = deact_code_i;
    assign cap_o    = LVL_W'({q_size_i, 8'h00}) + LVL_W'(BLOCK_BYTES);

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        rxq_fc_code2thr #(.LVL_W(LVL_W), .CODE_W(CODE_W)) conv_i (
            .cap_i   (cap_o),
            .code_i  (codes[g]),
            .thr_o   (thrs[g]),
            .legal_o (legal[g])
        );
    end

    assign act_thr_o   = thrs[0];
    assign deact_thr_o = thrs[1];
    assign cfg_ok_o    = (cap_o >= LVL_W'(MIN_CAP)) && (&legal)
                         && (act_code_i < deact_code_i);
endmodule

// File: rtl/rxq_fc_fsm.sv
module rxq_fc_fsm
    import rxq_fc_pkg::*;
#(
    parameter int unsigned LVL_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             cfg_ok_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0] cap_i,
    input  logic [LVL_W-1:0] act_thr_i,
    input  logic [LVL_W-1:0] deact_thr_i,
    output logic             req_o,
    output logic [1:0]       stat_o
);
    fc_state_e  state_q, state_d;
    fill_stat_e stat;

    always_comb begin
        state_d = state_q;
        if (!en_i || !cfg_ok_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_RELEASED:
                    state_d = (lvl_i >= act_thr_i) ? ST_ASSERTED : ST_RELEASED;
                ST_ASSERTED:
                    if (lvl_i < deact_thr_i) state_d = ST_RELEASED;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        req_o = en_i && cfg_ok_i && (state_q == ST_ASSERTED);
        if (lvl_i == '0)                 stat = FILL_EMPTY;
        else if (lvl_i >= cap_i)         stat = FILL_FULL;
        else if (state_q == ST_ASSERTED) stat = FILL_HIGH;
        else                             stat = FILL_LOW;
        stat_o = stat;
    end

    // R3
    act_cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(state_q == ST_ASSERTED) |-> $past(lvl_i >= act_thr_i));
    // R4
    release_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(state_q == ST_ASSERTED) |->
            $past(!en_i || !cfg_ok_i || (lvl_i < deact_thr_i)));
    // R8
    asserted_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ASSERTED) |-> $past(cfg_ok_i && en_i));
    // R9
    thr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_ok_i |-> (act_thr_i > deact_thr_i));
endmodule

// File: rtl/rxq_fc_monitor.sv
module rxq_fc_monitor
    import rxq_fc_pkg::*;
#(
    parameter int unsigned SIZE_W = 7,
    parameter int unsigned CODE_W = 6,
    parameter int unsigned LVL_W  = SIZE_W + 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fc_en_i,
    input  logic [SIZE_W-1:0] q_size_i,
    input  logic [CODE_W-1:0] act_code_i,
    input  logic [CODE_W-1:0] deact_code_i,
    input  logic [LVL_W-1:0]  fill_lvl_i,
    output logic              fc_req_o,
    output logic [1:0]        fill_stat_o
);
    logic [LVL_W-1:0] cap, act_thr, deact_thr;
    logic             cfg_ok;

    rxq_fc_cfg #(.LVL_W(LVL_W), .SIZE_W(SIZE_W), .CODE_W(CODE_W)) cfg_i (
        .q_size_i     (q_size_i),
        .act_code_i   (act_code_i),
        .deact_code_i (deact_code_i),
        .cap_o        (cap),
        .act_thr_o    (act_thr),
        .deact_thr_o  (deact_thr),
        .cfg_ok_o     (cfg_ok)
    );

    rxq_fc_fsm #(.LVL_W(LVL_W)) fsm_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (fc_en_i),
        .cfg_ok_i    (cfg_ok),
        .lvl_i       (fill_lvl_i),
        .cap_i       (cap),
        .act_thr_i   (act_thr),
        .deact_thr_i (deact_thr),
        .req_o       (fc_req_o),
        .stat_o      (fill_stat_o)
    );
endmodule

// File: tb/rxq_fc_monitor_tb.sv
module rxq_fc_monitor_tb_top;
    localparam int SIZE_W = 7;
    localparam int CODE_W = 6;
    localparam int LVL_W  = SIZE_W + 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [SIZE_W-1:0] size = '0;
    logic [CODE_W-1:0] act = '0;
    logic [CODE_W-1:0] deact = '0;
    logic [LVL_W-1:0]  lvl = '0;
    logic              req;
    logic [1:0]        stat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    bit    q_req [$];
    int    q_st  [$];
    string q_tag [$];

    always #4 clk = ~clk;

    rxq_fc_monitor #(.SIZE_W(SIZE_W), .CODE_W(CODE_W), .LVL_W(LVL_W)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .fc_en_i      (en),
        .q_size_i     (size),
        .act_code_i   (act),
        .deact_code_i (deact),
        .fill_lvl_i   (lvl),
        .fc_req_o     (req),
        .fill_stat_o  (stat)
    );

    function automatic void compare(bit er, int es, string tag);
        n_cmp++;
        if (req !== er || int'(stat) != es) begin
            n_bad++;
            $display("FAIL %s: req=%0b stat=%0d expected req=%0b stat=%0d",
                     tag, req, stat, er, es);
        end
    endfunction

    // monitor: pops one expectation per falling edge
    always @(negedge clk) begin
        if (q_req.size() > 0) begin
            compare(q_req.pop_front(), q_st.pop_front(), q_tag.pop_front());
        end
    end

    task automatic step(bit e, int s, int a, int d, int l, bit er, int es, string tag);
        @(negedge clk);
        #1;
        en = e; size = SIZE_W'(s); act = CODE_W'(a); deact = CODE_W'(d); lvl = LVL_W'(l);
        q_req.push_back(er); q_st.push_back(es); q_tag.push_back(tag);
    endtask

    initial begin
        #2;
        compare(1'b0, 0, "R10 reset");
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // size 15 -> 4096 bytes; act code 0 -> 3072, deact code 2 -> 2048
        step(1, 15, 0, 2, 0,    0, 0, "R2 empty armed");
        step(1, 15, 0, 2, 1000, 0, 1, "R6 below threshold");
        step(1, 15, 0, 2, 3071, 0, 1, "R6 one below activate");
        step(1, 15, 0, 2, 3072, 1, 2, "R3 activate at threshold");
        step(1, 15, 0, 2, 2500, 1, 2, "R5 between stays on");
        step(1, 15, 0, 2, 2048, 1, 2, "R5 at deactivate stays on");
        step(1, 15, 0, 2, 2047, 0, 1, "R4 release below deactivate");
        step(1, 15, 0, 2, 2500, 0, 1, "R5 between stays off");
        step(1, 15, 0, 2, 4096, 1, 3, "R1 full status");
        step(1, 15, 0, 2, 0,    0, 0, "R2 empty releases");
        step(1, 15, 0, 2, 3500, 1, 2, "R3 re-activate");
        // immediate disable
        @(negedge clk);
        #1 en = 1'b0;
        #1 n_cmp++;
        if (req !== 1'b0) begin
            n_bad++;
            $display("FAIL R7 same-cycle disable: req=%0b expected req=0", req);
        end
        q_req.push_back(1'b0); q_st.push_back(1); q_tag.push_back("R7 idle after disable");
        step(1, 14, 0, 2, 3500, 0, 1, "R8 capacity under 4KB");
        step(1, 15, 0, 6, 3500, 0, 1, "R9 illegal deactivate code");
        step(1, 15, 3, 3, 3500, 0, 1, "R9 equal codes");
        // size 31 -> 8192; act 2 -> 6144, deact 8 -> 3072
        step(1, 31, 2, 8, 6143, 0, 1, "R3 large queue below");
        step(1, 31, 2, 8, 6144, 1, 2, "R3 large queue activate");
        step(1, 31, 2, 8, 3072, 1, 2, "R5 large queue hold");
        step(1, 31, 2, 8, 3071, 0, 1, "R4 large queue release");
        // largest legal deactivate code at 4096 is 5 -> 512 bytes
        step(1, 15, 0, 5, 3072, 1, 2, "R9 top legal code on");
        step(1, 15, 0, 5, 512,  1, 2, "R5 at 512 held");
        step(1, 15, 0, 5, 511,  0, 1, "R4 release under 512");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule